// File: doc/BRIEF.md
# Multi-channel DMA completion scheduler

This block keeps the timing and sequencing state for twelve DMA channels. A host arms a channel either with a complete transfer descriptor (direct mode) or with only a pointer to a descriptor held in memory (chained mode). Each armed channel counts down a number of cycles taken from its source word count. When the count runs out, the block fires a per-channel execute strobe for the external data mover. It also sets the channel's interrupt latch bit and, if the mask allows, its active-interrupt bit. It then either frees the channel or, when a chain pointer is present, fetches the next descriptor from memory and arms the channel again.

The arm interface is a valid/ready stream. `arm_ready` is held high, so an arm beat is consumed on every cycle in which `arm_valid` is high. A beat that cannot be honoured is reported on `arm_err` and changes nothing. The descriptor read port is a valid/ready request stream. The memory may hold `rd_ready` low for any number of cycles. While it does so, the request and its address stay frozen. Read data returns on `rd_data` exactly one cycle after each accepted request, and that return path has no back-pressure. The data mover reads the fields of any channel through the combinational `view_*` port.

Top module: `dma_done_sched`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every busy bit, timer, execute strobe, interrupt latch and active-interrupt bit, and leaves `rd_valid` low.
- R2: `arm_ready` is always 1. A direct arm (`arm_chain_start`=0) of an idle channel n is taken at the clock edge, and `busy[n]` reads 1 from the next cycle. From then on, `view_*` for n shows the armed source, destination, modifiers, counts and packing mode, with a chain pointer of 0.
- R3: A channel armed at edge E completes at edge E+max(1, src_count/4), using integer division. After that edge, `exec_pulse[n]` is high for exactly one cycle, and `busy[n]` drops unless the chain pointer is nonzero.
- R4: Completion of channel n sets `irq_latch[n+10]`. It also sets `irq_active[n+10]` only if `irq_mask[n+10]` is 1 at that edge. Bits 0 to 9 of both outputs stay 0, and set bits stay set until reset.
- R5: An arm beat to a busy channel, to a channel number of 12 or more, or in chained mode with `arm_cp`=0, raises `arm_err` for one cycle and leaves all channel state unchanged.
- R6: A channel with a nonzero chain pointer CP stays busy after completion. It reads seven words, in this order, from CP, CP-1, CP-2, CP-3, CP-5, CP-6 and CP-7. These are the internal index, internal modifier, internal count, next chain pointer, external index, external modifier and external count. The word at CP-4 is skipped.
- R7: If the stored direction bit is 1 (transmit), the external words become the destination and the internal words become the source. If it is 0 (receive), the mapping is the other way round. A direct arm also stores `arm_dir`.
- R8: A fetched descriptor always has packing mode 0. Its chain pointer is the word read from CP-3. The channel is re-armed, per R3, at the edge that captures the seventh word. A chain ends at a descriptor whose next pointer is 0.
- R9: Only one descriptor fetch runs at a time. When the fetcher is free, it takes the lowest-numbered channel that is waiting for a fetch.
- R10: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_addr` holds its value on the next cycle.
- R11: Channels time out independently. Any number of them can be busy at once, and several can complete at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arm_valid | input | 1 | Arm beat present |
| arm_ready | output | 1 | Arm beat accepted (always 1) |
| arm_chan | input | 4 | Target channel |
| arm_chain_start | input | 1 | 1: start a chain from `arm_cp`; 0: direct descriptor |
| arm_dir | input | 1 | Chain direction, 1 transmit, 0 receive |
| arm_cp | input | 32 | First descriptor pointer (chained mode) |
| arm_src | input | 32 | Source index (direct mode) |
| arm_dst | input | 32 | Destination index (direct mode) |
| arm_src_mod | input | 32 | Source modifier |
| arm_dst_mod | input | 32 | Destination modifier |
| arm_src_cnt | input | 32 | Source count, sets the countdown |
| arm_dst_cnt | input | 32 | Destination count |
| arm_pmode | input | 2 | Packing mode (direct mode) |
| arm_err | output | 1 | One-cycle flag for a refused arm beat |
| busy | output | 12 | Per-channel busy status |
| exec_pulse | output | 12 | Per-channel one-cycle transfer-execute strobe |
| irq_mask | input | 22 | Interrupt mask |
| irq_latch | output | 22 | Interrupt latch, channel n at bit n+10 |
| irq_active | output | 22 | Masked active interrupts |
| rd_valid | output | 1 | Descriptor read request |
| rd_ready | input | 1 | Memory accepts the request |
| rd_addr | output | 32 | Descriptor word address |
| rd_data | input | 32 | Read data, one cycle after acceptance |
| view_chan | input | 4 | Channel selected for the view port |
| view_src | output | 32 | Selected channel source index |
| view_dst | output | 32 | Selected channel destination index |
| view_src_mod | output | 32 | Selected channel source modifier |
| view_dst_mod | output | 32 | Selected channel destination modifier |
| view_src_cnt | output | 32 | Selected channel source count |
| view_dst_cnt | output | 32 | Selected channel destination count |
| view_pmode | output | 2 | Selected channel packing mode |
| view_chain | output | 32 | Selected channel chain pointer |

## Verification
- An arm beat taken at one edge shows up on `busy`, `arm_err` and the view port in the following cycle.
- Completion lands exactly max(1, src_count/4) edges after arming. Its strobe and interrupt bits become visible in the cycle after that edge.
- A chained channel is granted the fetcher one edge after it starts waiting. It issues its first read in the next cycle, and it re-arms at the edge that captures the seventh word, which returns one cycle after the last accepted request.
- The bench model advances on the same edges under the same stall pattern on `rd_ready`. Every output, including `rd_addr`, is compared on the falling edge, half a cycle after any change.

// File: rtl/dmasched_pkg.sv
package dmasched_pkg;
  localparam int DW     = 32;
  localparam int PMW    = 2;
  localparam int NWORDS = 7;   // words fetched per chained descriptor
  localparam int GAP    = 4;   // slot skipped in memory (CP-4)

  // fetch slot numbers
  localparam int SL_INT_IDX = 0;
  localparam int SL_INT_MOD = 1;
  localparam int SL_INT_CNT = 2;
  localparam int SL_NEXT    = 3;
  localparam int SL_EXT_IDX = 4;
  localparam int SL_EXT_MOD = 5;
  localparam int SL_EXT_CNT = 6;

  typedef logic [DW-1:0] word_t;

  typedef struct packed {
    word_t          src;
    word_t          dst;
    word_t          src_mod;
    word_t          dst_mod;
    word_t          src_cnt;
    word_t          dst_cnt;
    word_t          chain;
    logic [PMW-1:0] pmode;
  } desc_t;

  typedef enum logic [1:0] {CH_IDLE, CH_RUN, CH_PEND, CH_FETCH} ch_state_e;

  // distance below the chain pointer for fetch slot k
  function automatic int unsigned slot_offset(input int unsigned k);
    return (k >= GAP) ? k + 1 : k;
  endfunction
endpackage

// File: rtl/dmasched_chan.sv
module dmasched_chan import dmasched_pkg::*; (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          host_arm,
  input  logic                          host_chain_start,
  input  logic                          host_dir,
  input  word_t                         host_cp,
  input  desc_t                         host_desc,
  input  logic                          grant,
  input  logic                          fetch_done,
  input  logic [NWORDS-1:0][DW-1:0]     fetch_words,
  output logic                          busy,
  output logic                          pend,
  output logic                          expire,
  output desc_t                         desc
);
  localparam int TW = DW - 2;

  ch_state_e         state;
  logic [TW-1:0]     timer;
  logic              dir;
  desc_t             mapped;

  assign busy   = (state != CH_IDLE);
  assign pend   = (state == CH_PEND);
  assign expire = (state == CH_RUN) && (timer <= TW'(1));

  // direction decides which half of the fetched block is the source
  always_comb begin
    mapped       = '0;
    mapped.chain = fetch_words[SL_NEXT];
    mapped.pmode = '0;
    if (dir) begin
      mapped.src     = fetch_words[SL_INT_IDX];
      mapped.src_mod = fetch_words[SL_INT_MOD];
      mapped.src_cnt = fetch_words[SL_INT_CNT];
      mapped.dst     = fetch_words[SL_EXT_IDX];
      mapped.dst_mod = fetch_words[SL_EXT_MOD];
      mapped.dst_cnt = fetch_words[SL_EXT_CNT];
    end else begin
      mapped.src     = fetch_words[SL_EXT_IDX];
      mapped.src_mod = fetch_words[SL_EXT_MOD];
      mapped.src_cnt = fetch_words[SL_EXT_CNT];
      mapped.dst     = fetch_words[SL_INT_IDX];
      mapped.dst_mod = fetch_words[SL_INT_MOD];
      mapped.dst_cnt = fetch_words[SL_INT_CNT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= CH_IDLE;
      timer <= '0;
      dir   <= 1'b0;
      desc  <= '0;
    end else begin
      unique case (state)
        CH_IDLE: if (host_arm) begin
          dir <= host_dir;
          if (host_chain_start) begin
            desc.chain <= host_cp;
            state      <= CH_PEND;
          end else begin
            desc  <= host_desc;
            timer <= host_desc.src_cnt[DW-1:2];
            state <= CH_RUN;
          end
        end
        CH_RUN: begin
          if (expire) state <= (desc.chain != '0) ? CH_PEND : CH_IDLE;
          else        timer <= timer - TW'(1);
        end
        CH_PEND: if (grant) state <= CH_FETCH;
        CH_FETCH: if (fetch_done) begin
          desc  <= mapped;
          timer <= mapped.src_cnt[DW-1:2];
          state <= CH_RUN;
        end
        default: state <= CH_IDLE;
      endcase
    end
  end

  // R3: a completion is never followed by a second one on the next edge
  assert_single_expire_R3: assert property (@(posedge clk) disable iff (rst)
    expire |=> !expire);
  // R5: the top only forwards arm beats to idle channels
  assert_arm_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
    host_arm |-> (state == CH_IDLE));
  // R9: fetcher grants and completions only reach a channel that waits for them
  assert_grant_pending_R9: assert property (@(posedge clk) disable iff (rst)
    grant |-> (state == CH_PEND));
  assert_done_fetching_R8: assert property (@(posedge clk) disable iff (rst)
    fetch_done |-> (state == CH_FETCH));
endmodule

// File: rtl/dmasched_fetch.sv
module dmasched_fetch import dmasched_pkg::*; #(
  parameter int NCH = 12
)(
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NCH-1:0]                pend,
  input  logic [NCH-1:0][DW-1:0]        cps,
  output logic [NCH-1:0]                grant,
  output logic [NCH-1:0]                done,
  output logic [NWORDS-1:0][DW-1:0]     words,
  output logic                          rd_valid,
  input  logic                          rd_ready,
  output word_t                         rd_addr,
  input  word_t                         rd_data
);
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int IW = $clog2(NWORDS + 1);

  logic                        active;
  logic [SW-1:0]               cur;
  logic [SW-1:0]               gidx;
  word_t                       base;
  logic [IW-1:0]               req_idx;
  logic                        rsp_vld;
  logic [IW-1:0]               rsp_idx;
  logic [NWORDS-1:0][DW-1:0]   wbuf;
  logic                        last;
  logic                        hs;

  // lowest waiting channel wins
  always_comb begin
    grant = '0;
    gidx  = '0;
    if (!active) begin
      for (int i = NCH - 1; i >= 0; i--) begin
        if (pend[i]) begin
          grant    = '0;
          grant[i] = 1'b1;
          gidx     = SW'(i);
        end
      end
    end
  end

  assign rd_valid = active && (req_idx < IW'(NWORDS));
  assign rd_addr  = base - DW'(slot_offset(32'(req_idx)));
  assign hs       = rd_valid && rd_ready;
  assign last     = rsp_vld && (rsp_idx == IW'(NWORDS - 1));

  always_comb begin
    done = '0;
    if (last) done[cur] = 1'b1;
  end

  generate
    for (genvar k = 0; k < NWORDS; k++) begin : g_word
      if (k == NWORDS - 1) begin : g_live
        assign words[k] = rd_data;
      end else begin : g_held
        assign words[k] = wbuf[k];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      cur     <= '0;
      base    <= '0;
      req_idx <= '0;
      rsp_vld <= 1'b0;
      rsp_idx <= '0;
      wbuf    <= '0;
    end else begin
      rsp_vld <= hs;
      if (hs) begin
        rsp_idx <= req_idx;
        req_idx <= req_idx + IW'(1);
      end
      if (rsp_vld && (rsp_idx < IW'(NWORDS - 1))) wbuf[rsp_idx] <= rd_data;
      if (last) active <= 1'b0;
      if (!active && (|pend)) begin
        active  <= 1'b1;
        cur     <= gidx;
        base    <= cps[gidx];
        req_idx <= '0;
      end
    end
  end

  // R10: a stalled request holds its address
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
  // R9: at most one channel granted at a time
  assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  // R6: a fetch ends on exactly one channel
  assert_done_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done));
endmodule

// File: rtl/dma_done_sched.sv
module dma_done_sched import dmasched_pkg::*; #(
  parameter int NCH      = 12,
  parameter int IRQ_BASE = 10,
  parameter int CHW      = 4,
  localparam int IRQW    = NCH + IRQ_BASE
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              arm_valid,
  output logic              arm_ready,
  input  logic [CHW-1:0]    arm_chan,
  input  logic              arm_chain_start,
  input  logic              arm_dir,
  input  logic [DW-1:0]     arm_cp,
  input  logic [DW-1:0]     arm_src,
  input  logic [DW-1:0]     arm_dst,
  input  logic [DW-1:0]     arm_src_mod,
  input  logic [DW-1:0]     arm_dst_mod,
  input  logic [DW-1:0]     arm_src_cnt,
  input  logic [DW-1:0]     arm_dst_cnt,
  input  logic [PMW-1:0]    arm_pmode,
  output logic              arm_err,
  output logic [NCH-1:0]    busy,
  output logic [NCH-1:0]    exec_pulse,
  input  logic [IRQW-1:0]   irq_mask,
  output logic [IRQW-1:0]   irq_latch,
  output logic [IRQW-1:0]   irq_active,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DW-1:0]     rd_addr,
  input  logic [DW-1:0]     rd_data,
  input  logic [CHW-1:0]    view_chan,
  output logic [DW-1:0]     view_src,
  output logic [DW-1:0]     view_dst,
  output logic [DW-1:0]     view_src_mod,
  output logic [DW-1:0]     view_dst_mod,
  output logic [DW-1:0]     view_src_cnt,
  output logic [DW-1:0]     view_dst_cnt,
  output logic [PMW-1:0]    view_pmode,
  output logic [DW-1:0]     view_chain
);
  logic [NCH-1:0]              busy_w, pend_w, expire_w, host_arm, grant_w, done_w;
  desc_t                       desc_w [NCH];
  logic [NCH-1:0][DW-1:0]      cps;
  logic [NWORDS-1:0][DW-1:0]   fwords;
  desc_t                       host_desc;
  desc_t                       view_d;
  logic                        sel_busy;
  logic                        accept;

  assign arm_ready = 1'b1;

  always_comb begin
    host_desc         = '0;
    host_desc.src     = arm_src;
    host_desc.dst     = arm_dst;
    host_desc.src_mod = arm_src_mod;
    host_desc.dst_mod = arm_dst_mod;
    host_desc.src_cnt = arm_src_cnt;
    host_desc.dst_cnt = arm_dst_cnt;
    host_desc.pmode   = arm_pmode;
    host_desc.chain   = '0;
  end

  // out-of-range channel numbers look busy, so they are refused
  always_comb begin
    sel_busy = 1'b1;
    for (int i = 0; i < NCH; i++)
      if (arm_chan == CHW'(i)) sel_busy = busy_w[i];
  end

  assign accept = arm_valid && !sel_busy && !(arm_chain_start && (arm_cp == '0));

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      assign host_arm[g] = accept && (arm_chan == CHW'(g));
      assign cps[g]      = desc_w[g].chain;
      dmasched_chan u_chan (
        .clk              (clk),
        .rst              (rst),
        .host_arm         (host_arm[g]),
        .host_chain_start (arm_chain_start),
        .host_dir         (arm_dir),
        .host_cp          (arm_cp),
        .host_desc        (host_desc),
        .grant            (grant_w[g]),
        .fetch_done       (done_w[g]),
        .fetch_words      (fwords),
        .busy             (busy_w[g]),
        .pend             (pend_w[g]),
        .expire           (expire_w[g]),
        .desc             (desc_w[g])
      );
    end
  endgenerate

  dmasched_fetch #(.NCH(NCH)) u_fetch (
    .clk      (clk),
    .rst      (rst),
    .pend     (pend_w),
    .cps      (cps),
    .grant    (grant_w),
    .done     (done_w),
    .words    (fwords),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      exec_pulse <= '0;
      irq_latch  <= '0;
      irq_active <= '0;
      arm_err    <= 1'b0;
    end else begin
      exec_pulse <= expire_w;
      irq_latch  <= irq_latch | {expire_w, {IRQ_BASE{1'b0}}};
      irq_active <= irq_active | ({expire_w, {IRQ_BASE{1'b0}}} & irq_mask);
      arm_err    <= arm_valid && !accept;
    end
  end

  assign busy = busy_w;

  always_comb begin
    view_d = '0;
    for (int i = 0; i < NCH; i++)
      if (view_chan == CHW'(i)) view_d = desc_w[i];
  end

  assign view_src     = view_d.src;
  assign view_dst     = view_d.dst;
  assign view_src_mod = view_d.src_mod;
  assign view_dst_mod = view_d.dst_mod;
  assign view_src_cnt = view_d.src_cnt;
  assign view_dst_cnt = view_d.dst_cnt;
  assign view_pmode   = view_d.pmode;
  assign view_chain   = view_d.chain;

  // R4: an active interrupt is always also latched
  assert_active_in_latch_R4: assert property (@(posedge clk) disable iff (rst)
    (irq_active & ~irq_latch) == '0);
  // R3: an execute strobe lasts one cycle per completion
  assert_exec_once_R3: assert property (@(posedge clk) disable iff (rst)
    (exec_pulse != '0) |=> ((exec_pulse & $past(exec_pulse)) == '0));
  // R5: a refused beat does not disturb the busy bits of idle channels
  assert_err_no_arm_R5: assert property (@(posedge clk) disable iff (rst)
    (arm_valid && !accept) |-> (host_arm == '0));
endmodule

// File: tb/dma_done_sched_bench.sv
module dma_done_sched_bench;
  localparam int NCH = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arm_valid = 1'b0, arm_chain_start = 1'b0, arm_dir = 1'b0;
  logic [3:0] arm_chan = '0;
  logic [31:0] arm_cp = '0, arm_src = '0, arm_dst = '0, arm_src_mod = '0;
  logic [31:0] arm_dst_mod = '0, arm_src_cnt = '0, arm_dst_cnt = '0;
  logic [1:0] arm_pmode = '0;
  logic [21:0] irq_mask = '0;
  logic rd_ready = 1'b1;
  logic [31:0] rd_data = '0;
  logic [3:0] view_chan = '0;
  logic arm_ready, arm_err, rd_valid;
  logic [11:0] busy, exec_pulse;
  logic [21:0] irq_latch, irq_active;
  logic [31:0] rd_addr, view_src, view_dst, view_src_mod, view_dst_mod;
  logic [31:0] view_src_cnt, view_dst_cnt, view_chain;
  logic [1:0] view_pmode;

  always #4 clk = ~clk;

  dma_done_sched u_dma_done_sched (
    .clk(clk), .rst(rst), .arm_valid(arm_valid), .arm_ready(arm_ready),
    .arm_chan(arm_chan), .arm_chain_start(arm_chain_start), .arm_dir(arm_dir),
    .arm_cp(arm_cp), .arm_src(arm_src), .arm_dst(arm_dst),
    .arm_src_mod(arm_src_mod), .arm_dst_mod(arm_dst_mod),
    .arm_src_cnt(arm_src_cnt), .arm_dst_cnt(arm_dst_cnt), .arm_pmode(arm_pmode),
    .arm_err(arm_err), .busy(busy), .exec_pulse(exec_pulse), .irq_mask(irq_mask),
    .irq_latch(irq_latch), .irq_active(irq_active), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .view_chan(view_chan), .view_src(view_src), .view_dst(view_dst),
    .view_src_mod(view_src_mod), .view_dst_mod(view_dst_mod),
    .view_src_cnt(view_src_cnt), .view_dst_cnt(view_dst_cnt),
    .view_pmode(view_pmode), .view_chain(view_chain));

  int checks = 0, errors = 0;
  logic [31:0] mem [256];
  bit stall_en = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string what, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", what, cyc, act, exp);
    end
  endtask

  // memory: one-cycle read latency after each accepted request
  always @(posedge clk) if (rd_valid && rd_ready) rd_data <= mem[rd_addr[7:0]];

  // ---------------- reference model ----------------
  int ms [NCH];               // 0 idle, 1 counting, 2 waiting fetch, 3 fetching
  int unsigned mt [NCH];
  logic [31:0] msrc[NCH], mdst[NCH], msm[NCH], mdm[NCH], msc[NCH], mdc[NCH], mch[NCH];
  logic [1:0] mpm[NCH];
  bit mdir[NCH];
  bit f_act, f_rsp;
  int f_ch, f_req, f_ridx;
  logic [31:0] f_base;
  logic [31:0] fw[7];
  logic [11:0] e_exec;
  logic [21:0] e_latch, e_act;
  bit e_err;

  always @(posedge clk) begin
    logic [11:0] xp;
    int g, ac;
    bit lst, hs, err;
    if (rst) begin
      for (int n = 0; n < NCH; n++) begin
        ms[n] = 0; mt[n] = 0; msrc[n] = 0; mdst[n] = 0; msm[n] = 0; mdm[n] = 0;
        msc[n] = 0; mdc[n] = 0; mch[n] = 0; mpm[n] = 0; mdir[n] = 0;
      end
      f_act = 0; f_rsp = 0; f_ch = 0; f_req = 0; f_ridx = 0; f_base = 0;
      for (int k = 0; k < 7; k++) fw[k] = 0;
      e_exec = 0; e_latch = 0; e_act = 0; e_err = 0;
    end else begin
      for (int n = 0; n < NCH; n++) xp[n] = (ms[n] == 1) && (mt[n] <= 1);
      ac  = int'(arm_chan);
      err = arm_valid && !((ac < NCH) && (ms[ac] == 0) && !(arm_chain_start && arm_cp == 0));
      lst = f_rsp && (f_ridx == 6);
      hs  = f_act && (f_req < 7) && rd_ready;
      g = -1;
      if (!f_act) for (int n = NCH - 1; n >= 0; n--) if (ms[n] == 2) g = n;
      for (int n = 0; n < NCH; n++) begin
        case (ms[n])
          0: if (arm_valid && !err && ac == n) begin
               mdir[n] = arm_dir;
               if (arm_chain_start) begin mch[n] = arm_cp; ms[n] = 2; end
               else begin
                 msrc[n] = arm_src; mdst[n] = arm_dst; msm[n] = arm_src_mod;
                 mdm[n] = arm_dst_mod; msc[n] = arm_src_cnt; mdc[n] = arm_dst_cnt;
                 mpm[n] = arm_pmode; mch[n] = 0; mt[n] = arm_src_cnt >> 2; ms[n] = 1;
               end
             end
          1: if (xp[n]) ms[n] = (mch[n] != 0) ? 2 : 0; else mt[n] = mt[n] - 1;
          2: if (g == n) ms[n] = 3;
          3: if (lst && f_ch == n) begin
               if (mdir[n]) begin
                 msrc[n] = fw[0]; msm[n] = fw[1]; msc[n] = fw[2];
                 mdst[n] = fw[4]; mdm[n] = fw[5]; mdc[n] = rd_data;
               end else begin
                 mdst[n] = fw[0]; mdm[n] = fw[1]; mdc[n] = fw[2];
                 msrc[n] = fw[4]; msm[n] = fw[5]; msc[n] = rd_data;
               end
               mch[n] = fw[3]; mpm[n] = 0; mt[n] = msc[n] >> 2; ms[n] = 1;
             end
          default: ;
        endcase
      end
      if (f_rsp && f_ridx < 6) fw[f_ridx] = rd_data;
      f_rsp = hs;
      if (hs) begin f_ridx = f_req; f_req++; end
      if (lst) f_act = 0;
      if (g >= 0) begin f_act = 1; f_ch = g; f_base = mch[g]; f_req = 0; end
      e_exec  = xp;
      e_latch = e_latch | {xp, 10'b0};
      e_act   = e_act | ({xp, 10'b0} & irq_mask);
      e_err   = err;
    end
  end

  // ---------------- per-cycle comparison ----------------
  int vsel = 0;
  always @(negedge clk) begin
    logic [11:0] eb;
    logic [31:0] ea;
    int off;
    cyc++;
    if (!rst) begin
      for (int n = 0; n < NCH; n++) eb[n] = (ms[n] != 0);
      check(busy == eb, "R2 R3 R11 busy", 256'(busy), 256'(eb));
      check(arm_ready == 1'b1, "R2 arm_ready", 256'(arm_ready), 256'(1));
      check(exec_pulse == e_exec, "R3 exec_pulse", 256'(exec_pulse), 256'(e_exec));
      check(irq_latch == e_latch, "R4 irq_latch", 256'(irq_latch), 256'(e_latch));
      check(irq_active == e_act, "R4 irq_active", 256'(irq_active), 256'(e_act));
      check(arm_err == e_err, "R5 arm_err", 256'(arm_err), 256'(e_err));
      check(rd_valid == (f_act && f_req < 7), "R6 R9 rd_valid", 256'(rd_valid), 256'(f_act && f_req < 7));
      if (f_act && f_req < 7) begin
        off = (f_req >= 4) ? f_req + 1 : f_req;
        ea = f_base - 32'(off);
        check(rd_addr == ea, "R6 R9 R10 rd_addr", 256'(rd_addr), 256'(ea));
      end
      view_chan = 4'(vsel);
      #1;
      check({view_src, view_dst, view_src_mod, view_dst_mod, view_src_cnt, view_dst_cnt, view_pmode, view_chain}
            == {msrc[vsel], mdst[vsel], msm[vsel], mdm[vsel], msc[vsel], mdc[vsel], mpm[vsel], mch[vsel]},
            "R2 R7 R8 view fields",
            256'({view_src, view_dst, view_src_mod, view_dst_cnt, view_pmode, view_chain}),
            256'({msrc[vsel], mdst[vsel], msm[vsel], mdc[vsel], mpm[vsel], mch[vsel]}));
      vsel = (vsel + 1) % NCH;
    end
    rd_ready = !(stall_en && ((cyc % 3) == 1 || (cyc % 7) == 0));
  end

  // ---------------- stimulus ----------------
  task automatic arm_direct(input int ch, input logic [31:0] sc, input logic [1:0] pm, input bit dr);
    @(negedge clk);
    arm_valid = 1; arm_chan = 4'(ch); arm_chain_start = 0; arm_dir = dr;
    arm_cp = 32'h55; arm_src = 32'h1000 + 32'(ch); arm_dst = 32'h2000 + 32'(ch);
    arm_src_mod = 1; arm_dst_mod = 2; arm_src_cnt = sc; arm_dst_cnt = sc + 1; arm_pmode = pm;
    @(posedge clk); #1 arm_valid = 0;
  endtask

  task automatic arm_chain(input int ch, input logic [31:0] cp, input bit dr);
    @(negedge clk);
    arm_valid = 1; arm_chan = 4'(ch); arm_chain_start = 1; arm_dir = dr; arm_cp = cp;
    arm_src = 32'hdead; arm_src_cnt = 32'h400;
    @(posedge clk); #1 arm_valid = 0;
  endtask

  task automatic put_desc(input int cp, input int ii, input int ic, input int nx, input int ei, input int ec);
    mem[cp]     = 32'(ii);  mem[cp - 1] = 32'(cp + 3);  mem[cp - 2] = 32'(ic);
    mem[cp - 3] = 32'(nx);  mem[cp - 4] = 32'hbad;      mem[cp - 5] = 32'(ei);
    mem[cp - 6] = 32'(cp + 9); mem[cp - 7] = 32'(ec);
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'((i * 5) & 63);
    put_desc(8'h40, 'h700, 8, 8'h60, 'h800, 12);
    put_desc(8'h60, 'h710, 4, 0, 'h810, 20);
    put_desc(8'h80, 'h720, 16, 8'ha0, 'h820, 6);
    put_desc(8'ha0, 'h730, 0, 8'hc0, 'h830, 2);
    put_desc(8'hc0, 'h740, 10, 0, 'h840, 9);
    irq_mask = 22'h200400;   // channels 0 and 11 enabled
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); #2;
    // R1: post-reset idle state
    check(busy == 0 && exec_pulse == 0 && irq_latch == 0 && irq_active == 0 && !rd_valid,
          "R1 reset state", 256'({busy, irq_latch, rd_valid}), 256'(0));
    // direct arms, overlapping channels (R2 R3 R11), minimum countdown
    arm_direct(0, 20, 2, 0);
    arm_direct(3, 2, 1, 1);
    arm_direct(11, 40, 3, 0);
    arm_direct(0, 4, 0, 0);          // busy: refused (R5)
    arm_direct(13, 4, 0, 0);         // out of range (R5)
    @(negedge clk);
    arm_valid = 1; arm_chan = 4; arm_chain_start = 1; arm_cp = 0;  // zero pointer (R5)
    @(posedge clk); #1 arm_valid = 0;
    idle(20);
    // chains in both directions (R6 R7 R8), contention for the fetcher (R9)
    arm_chain(7, 8'h40, 1);
    arm_chain(1, 8'h80, 0);
    arm_chain(5, 8'hc0, 1);
    idle(60);
    stall_en = 1;                    // back-pressure on reads (R10)
    arm_chain(2, 8'h80, 1);
    arm_chain(9, 8'h40, 0);
    idle(80);
    for (int i = 0; i < 400; i++) begin
      int ch, kind;
      ch = $urandom % 14; kind = $urandom % 3;
      if (kind == 0) arm_chain(ch, (($urandom % 4) == 0) ? 32'h0 : 32'(8'h40 + 8'h40 * ($urandom % 3)), 1'($urandom));
      else arm_direct(ch, 32'($urandom % 48), 2'($urandom), 1'($urandom));
      if (i == 200) stall_en = 0;
      idle($urandom % 4);
    end
    for (int i = 0; i < 3000 && (busy != 0 || rd_valid); i++) @(negedge clk);
    idle(4);
    check(busy == 0, "R3 R8 drained", 256'(busy), 256'(0));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired, R3 completion never reached: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule